// File: doc/BRIEF.md
# Region Cache Policy Selector

This block sorts every access address into one of a small number of address regions and reports the cache policy that applies there. The address space is cut by programmable region tops. Each top holds the last aligned block that still belongs to its region. The final region has no top and covers everything above the previous one. A single packed policy word holds a 2-bit policy for each region.

Software programs the tops and the policy word through a simple indexed write/read port. The lookup side takes an address with a valid strobe. One clock later it returns the same address together with the region index and the effective policy.

Top module: `region_policy_sel`

## Requirements
- R1: After reset, the region 0 top reads `2^SPAN_LOG2 - 2^ALIGN_LOG2` (with the defaults, 0x00FFF000), the other tops read zero, and the policy word reads 0x2 (region 0 is write-back, all other regions are non-cacheable). The lookup valid output is low.
- R2: Register index i, for i < NUM_REGIONS-1, is the top of region i. A write keeps only address bits [ADDR_W-1:ALIGN_LOG2], so the low ALIGN_LOG2 bits read back as zero.
- R3: An address belongs to the lowest-numbered region i whose top has aligned block bits greater than or equal to the address's bits [ADDR_W-1:ALIGN_LOG2]. If no top covers the address, it belongs to region NUM_REGIONS-1.
- R4: A region's top is inclusive. The whole aligned block at the top belongs to the region, and the block just after it belongs to the next region.
- R5: When the tops are not in increasing order and more than one top covers an address, the lower-numbered region wins.
- R6: Register index NUM_REGIONS-1 is the policy word. The policy of region i sits in bits [2i+1:2i], encoded 00 = non-cacheable, 01 = write-through, 10 = write-back.
- R7: The reserved policy code 11 is reported as 00 (non-cacheable).
- R8: An access presented with acc_valid_i in one cycle appears on the outputs in the next cycle with res_valid_o high and res_addr_o equal to the presented address. A cycle with acc_valid_i low gives res_valid_o low in the next cycle.
- R9: A register write and an access in the same cycle: the access uses the configuration from before the write.
- R10: Indices above NUM_REGIONS-1 read as zero, and writes to them change no register.
- R11: Policy word bits at and above 2*NUM_REGIONS are not stored and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | IDX_W | Register index (tops, then the policy word) |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Read data for reg_idx_i (combinational) |
| acc_valid_i | input | 1 | Access address valid |
| acc_addr_i | input | ADDR_W | Access address |
| res_valid_o | output | 1 | Lookup result valid |
| res_addr_o | output | ADDR_W | Registered access address |
| res_region_o | output | RGN_W | Region index of the registered address |
| res_policy_o | output | 2 | Effective policy of that region |

## Verification
On every cycle, the assertions check four things:
- the one-cycle valid pipeline and the registered address;
- that the reserved code never reaches the policy output;
- that the region index stays in range;
- that a write to an unmapped index leaves all stored state unchanged.

Only the bench scenarios can show the rest. These are the region decision at inclusive top boundaries, the lower-region priority with overlapping tops, the field position of each policy, and the reset defaults. They also cover masking of the low top bits and of the unused policy bits, and the ordering when a write and an access land in the same cycle.

// File: rtl/rcps_pkg.sv
package rcps_pkg;

    typedef enum logic [1:0] {
        POL_NONCACHE  = 2'b00,
        POL_WRTHROUGH = 2'b01,
        POL_WRBACK    = 2'b10,
        POL_RESERVED  = 2'b11
    } policy_e;

    // Reserved code collapses to non-cacheable.
    function automatic policy_e effective_policy(input logic [1:0] raw);
        return (raw == POL_RESERVED) ? POL_NONCACHE : policy_e'(raw);
    endfunction

endpackage

// File: rtl/rcps_regs.sv
module rcps_regs #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int NUM_REGIONS = 4,
    parameter int ALIGN_LOG2  = 12,
    parameter int SPAN_LOG2   = 24,
    parameter int IDX_W       = 3,
    parameter int TAG_W       = ADDR_W - ALIGN_LOG2,
    parameter int POL_W       = 2 * NUM_REGIONS
) (
    input  logic                                 clk_i,
    input  logic                                 rst_ni,
    input  logic                                 we_i,
    input  logic [IDX_W-1:0]                     idx_i,
    input  logic [DATA_W-1:0]                    wdata_i,
    output logic [DATA_W-1:0]                    rdata_o,
    output logic [NUM_REGIONS-2:0][TAG_W-1:0]    tops_o,
    output logic [POL_W-1:0]                     pol_o
);
    import rcps_pkg::*;

    localparam logic [IDX_W-1:0] POL_IDX  = IDX_W'(NUM_REGIONS - 1);
    localparam logic [TAG_W-1:0] DEF_TOP0 =
        TAG_W'((64'd1 << (SPAN_LOG2 - ALIGN_LOG2)) - 64'd1);
    localparam logic [POL_W-1:0] DEF_POL  = POL_W'(POL_WRBACK);

    typedef struct packed {
        logic [NUM_REGIONS-2:0][TAG_W-1:0] top;
        logic [POL_W-1:0]                  pol;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic wdata_unused;

    assign wdata_unused = ^wdata_i;

    always_comb begin
        cfg_d   = cfg_q;
        rdata_o = '0;
        for (int i = 0; i < NUM_REGIONS - 1; i++) begin
            if (idx_i == IDX_W'(i)) begin
                rdata_o = DATA_W'({cfg_q.top[i], {ALIGN_LOG2{1'b0}}});
                if (we_i) begin
                    cfg_d.top[i] = wdata_i[ADDR_W-1:ALIGN_LOG2];
                end
            end
        end
        if (idx_i == POL_IDX) begin
            rdata_o = DATA_W'(cfg_q.pol);
            if (we_i) begin
                cfg_d.pol = wdata_i[POL_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q     <= '0;
            cfg_q.top <= '0;
            cfg_q.top[0] <= DEF_TOP0;
            cfg_q.pol <= DEF_POL;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign tops_o = cfg_q.top;
    assign pol_o  = cfg_q.pol;

    // R10: a write to an index beyond the policy word leaves all state unchanged.
    p_unmapped_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && idx_i > POL_IDX) |=> ($stable(cfg_q.top) && $stable(cfg_q.pol)));

endmodule

// File: rtl/rcps_match.sv
module rcps_match #(
    parameter int NUM_REGIONS = 4,
    parameter int TAG_W       = 20,
    parameter int RGN_W       = 2
) (
    input  logic [TAG_W-1:0]                  tag_i,
    input  logic [NUM_REGIONS-2:0][TAG_W-1:0] tops_i,
    output logic [RGN_W-1:0]                  region_o
);
    logic [NUM_REGIONS-2:0] covered;

    // One comparator per programmable top; the top itself is inside its region.
    for (genvar g = 0; g < NUM_REGIONS - 1; g++) begin : g_cmp
        assign covered[g] = (tag_i <= tops_i[g]);
    end

    // Lowest covered region wins; otherwise the open-ended last region.
    always_comb begin
        region_o = RGN_W'(NUM_REGIONS - 1);
        for (int i = NUM_REGIONS - 2; i >= 0; i--) begin
            if (covered[i]) begin
                region_o = RGN_W'(i);
            end
        end
    end

endmodule

// File: rtl/region_policy_sel.sv
module region_policy_sel #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int NUM_REGIONS = 4,
    parameter int ALIGN_LOG2  = 12,
    parameter int SPAN_LOG2   = 24,
    parameter int IDX_W       = $clog2(NUM_REGIONS) + 1,
    parameter int RGN_W       = $clog2(NUM_REGIONS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_we_i,
    input  logic [IDX_W-1:0]  reg_idx_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic              acc_valid_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    output logic              res_valid_o,
    output logic [ADDR_W-1:0] res_addr_o,
    output logic [RGN_W-1:0]  res_region_o,
    output logic [1:0]        res_policy_o
);
    import rcps_pkg::*;

    localparam int TAG_W = ADDR_W - ALIGN_LOG2;
    localparam int POL_W = 2 * NUM_REGIONS;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [RGN_W-1:0]  region;
        logic [1:0]        policy;
    } res_t;

    logic [NUM_REGIONS-2:0][TAG_W-1:0] tops;
    logic [POL_W-1:0]                  pol_word;
    logic [RGN_W-1:0]                  hit_region;
    logic [1:0]                        raw_policy;
    res_t                              res_d, res_q;

    rcps_regs #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .NUM_REGIONS (NUM_REGIONS),
        .ALIGN_LOG2  (ALIGN_LOG2),
        .SPAN_LOG2   (SPAN_LOG2),
        .IDX_W       (IDX_W),
        .TAG_W       (TAG_W),
        .POL_W       (POL_W)
    ) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (reg_we_i),
        .idx_i   (reg_idx_i),
        .wdata_i (reg_wdata_i),
        .rdata_o (reg_rdata_o),
        .tops_o  (tops),
        .pol_o   (pol_word)
    );

    rcps_match #(
        .NUM_REGIONS (NUM_REGIONS),
        .TAG_W       (TAG_W),
        .RGN_W       (RGN_W)
    ) u_match (
        .tag_i    (acc_addr_i[ADDR_W-1:ALIGN_LOG2]),
        .tops_i   (tops),
        .region_o (hit_region)
    );

    always_comb begin
        raw_policy = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (hit_region == RGN_W'(i)) begin
                raw_policy = pol_word[2*i +: 2];
            end
        end
        res_d        = res_q;
        res_d.valid  = acc_valid_i;
        if (acc_valid_i) begin
            res_d.addr   = acc_addr_i;
            res_d.region = hit_region;
            res_d.policy = effective_policy(raw_policy);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid_o  = res_q.valid;
    assign res_addr_o   = res_q.addr;
    assign res_region_o = res_q.region;
    assign res_policy_o = res_q.policy;

    // R8: a valid access produces a valid result with its address one cycle later.
    p_valid_lat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_valid_i |=> (res_valid_o && res_addr_o == $past(acc_addr_i)));
    // R8: no access means no result.
    p_idle_lat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !acc_valid_i |=> !res_valid_o);
    // R7: the reserved code never leaves the block.
    p_no_reserved_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_valid_o |-> (res_policy_o != 2'b11));
    // R3: the reported region exists.
    p_region_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_valid_o |-> (int'(res_region_o) < NUM_REGIONS));

endmodule

// File: tb/region_policy_sel_tb.sv
module region_policy_sel_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        res_valid;
    logic [31:0] res_addr;
    logic [1:0]  res_region;
    logic [1:0]  res_policy;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    region_policy_sel u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .reg_we_i     (reg_we),
        .reg_idx_i    (reg_idx),
        .reg_wdata_i  (reg_wdata),
        .reg_rdata_o  (reg_rdata),
        .acc_valid_i  (acc_valid),
        .acc_addr_i   (acc_addr),
        .res_valid_o  (res_valid),
        .res_addr_o   (res_addr),
        .res_region_o (res_region),
        .res_policy_o (res_policy)
    );

    // {address, expected region, expected policy} with tops 0x000FF000,
    // 0x002FF000, 0x00FFF000 and policy word 0x39.
    localparam logic [35:0] VECS [0:7] = '{
        {32'h0000_0000, 2'd0, 2'b01},
        {32'h000F_FFFC, 2'd0, 2'b01},
        {32'h0010_0000, 2'd1, 2'b10},
        {32'h002F_FFFF, 2'd1, 2'b10},
        {32'h0030_0000, 2'd2, 2'b00},
        {32'h00FF_FFFF, 2'd2, 2'b00},
        {32'h0100_0000, 2'd3, 2'b00},
        {32'hFFFF_FFFF, 2'd3, 2'b00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = idx; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] data);
        reg_idx = idx;
        #1;
        data = reg_rdata;
    endtask

    task automatic look(input logic [31:0] a);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        check("R1 valid low", {31'd0, res_valid}, 32'd0);
        rd(3'd0, r); check("R1 top0", r, 32'h00FF_F000);
        rd(3'd1, r); check("R1 top1", r, 32'd0);
        rd(3'd2, r); check("R1 top2", r, 32'd0);
        rd(3'd3, r); check("R1 policy", r, 32'h2);
        look(32'h00AB_C000);
        check("R1 default region", {30'd0, res_region}, 32'd0);
        check("R1 default policy wb", {30'd0, res_policy}, 32'h2);

        // R2: low bits masked on top write
        wr(3'd0, 32'h0030_0ABC);
        rd(3'd0, r); check("R2 top low bits", r, 32'h0030_0000);

        // Main configuration, R11 upper policy bits dropped
        wr(3'd0, 32'h000F_F000);
        wr(3'd1, 32'h002F_F000);
        wr(3'd2, 32'h00FF_F000);
        wr(3'd3, 32'hFFFF_FF39);
        rd(3'd3, r); check("R11 policy upper bits", r, 32'h39);

        // R3 R4 R6 R7 R8 table
        for (int i = 0; i < 8; i++) begin
            look(VECS[i][35:4]);
            check("R8 valid", {31'd0, res_valid}, 32'd1);
            check("R8 addr", res_addr, VECS[i][35:4]);
            check("R3 R4 region", {30'd0, res_region}, {30'd0, VECS[i][3:2]});
            check("R6 R7 policy", {30'd0, res_policy}, {30'd0, VECS[i][1:0]});
        end
        @(negedge clk);
        check("R8 idle valid low", {31'd0, res_valid}, 32'd0);

        // R6: other field assignment, 0xE4 = r3:11 r2:10 r1:01 r0:00
        wr(3'd3, 32'h0000_00E4);
        look(32'h0030_0000);
        check("R6 region2 wb", {30'd0, res_policy}, 32'h2);
        look(32'h0010_0000);
        check("R6 region1 wt", {30'd0, res_policy}, 32'h1);
        look(32'h0000_1000);
        check("R6 region0 nc", {30'd0, res_policy}, 32'h0);
        look(32'h0200_0000);
        check("R7 region3 reserved", {30'd0, res_policy}, 32'h0);

        // R9: write and access in the same cycle
        @(negedge clk);
        reg_we = 1'b1; reg_idx = 3'd3; reg_wdata = 32'h0000_0039;
        acc_valid = 1'b1; acc_addr = 32'h0010_0000;
        @(negedge clk);
        reg_we = 1'b0; acc_valid = 1'b0;
        check("R9 old policy used", {30'd0, res_policy}, 32'h1);
        look(32'h0010_0000);
        check("R9 new policy after", {30'd0, res_policy}, 32'h2);

        // R10: unmapped index
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd5, r); check("R10 unmapped reads zero", r, 32'd0);
        rd(3'd0, r); check("R10 top0 kept", r, 32'h000F_F000);
        rd(3'd1, r); check("R10 top1 kept", r, 32'h002F_F000);
        rd(3'd3, r); check("R10 policy kept", r, 32'h39);
        look(32'h0030_0000);
        check("R10 lookup unchanged", {30'd0, res_region}, 32'd2);

        // R5: overlapping tops, lower region wins
        wr(3'd0, 32'h002F_F000);
        wr(3'd1, 32'h000F_F000);
        look(32'h0005_0000);
        check("R5 overlap lower wins", {30'd0, res_region}, 32'd0);
        wr(3'd0, 32'h0000_0000);
        look(32'h0000_0000);
        check("R5 zero top block0", {30'd0, res_region}, 32'd0);
        look(32'h0000_1000);
        check("R4 next block region1", {30'd0, res_region}, 32'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule